// File: doc/BRIEF.md
# Cluster-Routed Fast Interrupt Request Unit

This unit delivers fast inter-core interrupt requests among cores that are grouped into clusters. Each core has its own register port: it writes a 32-bit request word to either a same-cluster request register or a system-wide request register. The word names a destination core, a destination cluster and a request kind. The unit decodes every sender's word in parallel and merges all requests aimed at one core. It keeps one pending flag per core, and that flag drives the core's fast-interrupt output.

Each core can read and clear its own pending flag through a status register. It also owns a delay register, and this register sets how long a deferred request aimed at that core waits before it becomes pending. A request can also withdraw an earlier request to a core that has not yet been delivered. Requests whose address names a core or cluster that does not exist are dropped.

Core numbering is flat. The core with flat index `k` sits in cluster `k / CORES_PER_CLUSTER` at position `k % CORES_PER_CLUSTER`. Writes take effect at the clock edge that samples them. Reads are combinational.

Top module: `ipi_fast_cluster`

## Requirements
- R1: The request word puts the destination core in bits 7:0, the destination cluster in bits 23:16 and the kind in bits 29:28. The kind codes are 0 immediate, 1 retract, 2 deferred and 3 no-wake. The per-core register select codes are 0 same-cluster request, 1 system-wide request, 2 status and 3 delay.
- R2: A same-cluster request goes to the sender's own cluster. The cluster field of the word is ignored.
- R3: A system-wide request goes to the cluster named in bits 23:16.
- R4: An immediate request raises the destination core's `fiq` bit just after the clock edge that samples the write.
- R5: A no-wake request behaves exactly like an immediate request.
- R6: Status read bit 0 equals the core's pending flag, and all other read bits are 0. Writing 1 to status bit 0 clears the flag. Writing 0 to it has no effect.
- R7: A deferred request loads the destination core's delay value V. The `fiq` bit rises V+1 clock edges after the edge that samples the write. A new deferred request to the same core restarts the count.
- R8: The delay register is readable and writable by its own core. It is `CNT_W` bits wide and zero-extended on read. Its reset value is `CNT_RST` (default 0).
- R9: A retract request clears the destination core's pending flag and cancels any running countdown for that core. If an immediate or no-wake request reaches the same core in the same cycle, the flag is set anyway.
- R10: A request whose core field is at least `CORES_PER_CLUSTER` is discarded. A system-wide request whose cluster field is at least `NUM_CLUSTERS` is also discarded.
- R11: Requests from several senders to the same or different cores in one cycle all take effect. A new set request wins over a status clear in the same cycle.
- R12: After reset every `fiq` bit is 0, every status read is 0 and no countdown is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NCORES | Per-core write strobe |
| wr_sel | input | 2*NCORES | Per-core write register select, 2 bits per core |
| wr_data | input | 32*NCORES | Per-core write data, 32 bits per core |
| rd_sel | input | 2*NCORES | Per-core read register select, 2 bits per core |
| rd_data | output | 32*NCORES | Per-core combinational read data |
| fiq | output | NCORES | Per-core fast-interrupt line, equal to the pending flag |

## Verification
An immediate, no-wake, retract or status-clear write shows on `fiq` right after the edge that samples it. A deferred write with delay V shows V+1 edges later, and a delay-register write reads back after its own edge. The bench drives inputs at the falling edge and passes one rising edge per write. It then samples at the next falling edge. For deferred requests it counts exactly V and V+1 further falling edges, and checks that the line is still low at the first and high at the second. Retraction is checked part-way through a countdown, and the line is then watched well past the moment the countdown would have expired.

// File: rtl/ipi_fast_pkg.sv
package ipi_fast_pkg;
   localparam int WORD_W   = 32;
   localparam int CORE_LSB = 0;
   localparam int CLUS_LSB = 16;
   localparam int KIND_LSB = 28;
   localparam int FIELD_W  = 8;

   typedef enum logic [1:0] {
      REQ_NOW   = 2'd0,
      REQ_PULL  = 2'd1,
      REQ_LATER = 2'd2,
      REQ_QUIET = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      SEL_LOCAL  = 2'd0,
      SEL_GLOBAL = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_DELAY  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ipi_req_decode.sv
module ipi_req_decode
   import ipi_fast_pkg::*;
#(
   parameter int NUM_CLUSTERS      = 2,
   parameter int CORES_PER_CLUSTER = 4,
   parameter int SENDER_CLUSTER    = 0,
   localparam int NCORES           = NUM_CLUSTERS * CORES_PER_CLUSTER
) (
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output logic [NCORES-1:0] hit,
   output req_kind_e         kind
);
   logic               is_local;
   logic               is_req;
   logic [FIELD_W-1:0] core_f;
   logic [FIELD_W-1:0] tgt_clus;

   always_comb begin
      is_local = (reg_sel_e'(wr_sel) == SEL_LOCAL);
      is_req   = wr_en && (is_local || reg_sel_e'(wr_sel) == SEL_GLOBAL);
      core_f   = wr_data[CORE_LSB +: FIELD_W];
      tgt_clus = is_local ? FIELD_W'(SENDER_CLUSTER) : wr_data[CLUS_LSB +: FIELD_W];
      kind     = req_kind_e'(wr_data[KIND_LSB +: 2]);
   end

   // An out-of-range core or cluster field matches no slot and is dropped.
   for (genvar t = 0; t < NCORES; t++) begin : g_slot
      localparam logic [FIELD_W-1:0] T_CORE = FIELD_W'(t % CORES_PER_CLUSTER);
      localparam logic [FIELD_W-1:0] T_CLUS = FIELD_W'(t / CORES_PER_CLUSTER);
      assign hit[t] = is_req && (core_f == T_CORE) && (tgt_clus == T_CLUS);
   end
endmodule

// File: rtl/ipi_target_slot.sv
module ipi_target_slot #(
   parameter int CNT_W   = 16,
   parameter int CNT_RST = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_req,
   input  logic             defer_req,
   input  logic             retract_req,
   input  logic             ack,
   input  logic             delay_we,
   input  logic [CNT_W-1:0] delay_wdata,
   output logic             pending,
   output logic             due,
   output logic [CNT_W-1:0] delay_q
);
   logic             armed;
   logic [CNT_W-1:0] count;

   assign due = armed && (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         armed   <= 1'b0;
         count   <= '0;
         delay_q <= CNT_W'(CNT_RST);
      end else begin
         if (delay_we) delay_q <= delay_wdata;

         if (set_req)          pending <= 1'b1;
         else if (retract_req) pending <= 1'b0;
         else if (due)         pending <= 1'b1;
         else if (ack)         pending <= 1'b0;

         if (retract_req) begin
            armed <= 1'b0;
         end else if (defer_req) begin
            armed <= 1'b1;
            count <= delay_q;
         end else if (due) begin
            armed <= 1'b0;
         end else if (armed) begin
            count <= count - 1'b1;
         end
      end
   end
endmodule

// File: rtl/ipi_fast_cluster.sv
module ipi_fast_cluster
   import ipi_fast_pkg::*;
#(
   parameter int NUM_CLUSTERS      = 2,
   parameter int CORES_PER_CLUSTER = 4,
   parameter int CNT_W             = 16,
   parameter int CNT_RST           = 0,
   localparam int NCORES           = NUM_CLUSTERS * CORES_PER_CLUSTER
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NCORES-1:0]        wr_en,
   input  logic [2*NCORES-1:0]      wr_sel,
   input  logic [WORD_W*NCORES-1:0] wr_data,
   input  logic [2*NCORES-1:0]      rd_sel,
   output logic [WORD_W*NCORES-1:0] rd_data,
   output logic [NCORES-1:0]        fiq
);
   if (NUM_CLUSTERS < 1 || NUM_CLUSTERS > 256) begin : g_bad_clusters
      $error("NUM_CLUSTERS must be 1..256");
   end
   if (CORES_PER_CLUSTER < 1 || CORES_PER_CLUSTER > 256) begin : g_bad_cores
      $error("CORES_PER_CLUSTER must be 1..256");
   end
   if (CNT_W < 1 || CNT_W > WORD_W) begin : g_bad_cnt
      $error("CNT_W must be 1..32");
   end

   logic [NCORES-1:0]        hit_mx [NCORES];
   req_kind_e                kind_mx [NCORES];
   logic [NCORES*NCORES-1:0] hit_flat;
   logic [NCORES-1:0]        set_req, defer_req, retract_req, ack_req, due;

   for (genvar s = 0; s < NCORES; s++) begin : g_sender
      ipi_req_decode #(
         .NUM_CLUSTERS      (NUM_CLUSTERS),
         .CORES_PER_CLUSTER (CORES_PER_CLUSTER),
         .SENDER_CLUSTER    (s / CORES_PER_CLUSTER)
      ) u_dec (
         .wr_en   (wr_en[s]),
         .wr_sel  (wr_sel[2*s +: 2]),
         .wr_data (wr_data[WORD_W*s +: WORD_W]),
         .hit     (hit_mx[s]),
         .kind    (kind_mx[s])
      );
      assign hit_flat[s*NCORES +: NCORES] = hit_mx[s];
   end

   // Merge every sender's request per destination core.
   always_comb begin
      set_req     = '0;
      defer_req   = '0;
      retract_req = '0;
      for (int t = 0; t < NCORES; t++) begin
         for (int s = 0; s < NCORES; s++) begin
            if (hit_mx[s][t]) begin
               unique case (kind_mx[s])
                  REQ_NOW, REQ_QUIET: set_req[t]     = 1'b1;
                  REQ_PULL:           retract_req[t] = 1'b1;
                  REQ_LATER:          defer_req[t]   = 1'b1;
               endcase
            end
         end
      end
   end

   for (genvar t = 0; t < NCORES; t++) begin : g_target
      logic             sel_status, sel_delay;
      logic [CNT_W-1:0] delay_q;

      assign sel_status = wr_en[t] && reg_sel_e'(wr_sel[2*t +: 2]) == SEL_STATUS;
      assign sel_delay  = wr_en[t] && reg_sel_e'(wr_sel[2*t +: 2]) == SEL_DELAY;
      assign ack_req[t] = sel_status && wr_data[WORD_W*t];

      ipi_target_slot #(
         .CNT_W   (CNT_W),
         .CNT_RST (CNT_RST)
      ) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .set_req     (set_req[t]),
         .defer_req   (defer_req[t]),
         .retract_req (retract_req[t]),
         .ack         (ack_req[t]),
         .delay_we    (sel_delay),
         .delay_wdata (wr_data[WORD_W*t +: CNT_W]),
         .pending     (fiq[t]),
         .due         (due[t]),
         .delay_q     (delay_q)
      );

      always_comb begin
         unique case (reg_sel_e'(rd_sel[2*t +: 2]))
            SEL_STATUS: rd_data[WORD_W*t +: WORD_W] = {{(WORD_W-1){1'b0}}, fiq[t]};
            SEL_DELAY:  rd_data[WORD_W*t +: WORD_W] = WORD_W'(delay_q);
            default:    rd_data[WORD_W*t +: WORD_W] = '0;
         endcase
      end
   end
endmodule

// File: rtl/ipi_fast_cluster_chk.sv
module ipi_fast_cluster_chk
   import ipi_fast_pkg::*;
#(
   parameter int NUM_CLUSTERS      = 2,
   parameter int CORES_PER_CLUSTER = 4,
   localparam int NCORES           = NUM_CLUSTERS * CORES_PER_CLUSTER
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NCORES-1:0]          wr_en,
   input logic [2*NCORES-1:0]        wr_sel,
   input logic [WORD_W*NCORES-1:0]   wr_data,
   input logic [NCORES-1:0]          fiq,
   input logic [NCORES-1:0]          set_req,
   input logic [NCORES-1:0]          retract_req,
   input logic [NCORES-1:0]          ack_req,
   input logic [NCORES-1:0]          due,
   input logic [NCORES*NCORES-1:0]   hit_flat
);
   function automatic logic [NCORES-1:0] cluster_mask(int c);
      logic [NCORES-1:0] m = '0;
      for (int k = 0; k < NCORES; k++) m[k] = (k / CORES_PER_CLUSTER) == c;
      return m;
   endfunction

   for (genvar t = 0; t < NCORES; t++) begin : g_t
      p_set_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
         set_req[t] |=> fiq[t]);
      p_retract_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
         retract_req[t] && !set_req[t] |=> !fiq[t]);
      p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fiq[t]) |-> $past(set_req[t] || due[t]));
      p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ack_req[t] && !set_req[t] && !due[t] |=> !fiq[t]);
   end

   for (genvar s = 0; s < NCORES; s++) begin : g_s
      localparam logic [NCORES-1:0] OWN = cluster_mask(s / CORES_PER_CLUSTER);
      logic [NCORES-1:0] row;
      logic              wr_req, wr_loc;
      logic [7:0]        core_f;
      assign row    = hit_flat[s*NCORES +: NCORES];
      assign wr_loc = wr_en[s] && wr_sel[2*s +: 2] == 2'd0;
      assign wr_req = wr_en[s] && wr_sel[2*s +: 2] inside {2'd0, 2'd1};
      assign core_f = wr_data[WORD_W*s +: 8];

      p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(row));
      p_core_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
         wr_req && core_f >= 8'(CORES_PER_CLUSTER) |-> row == '0);
      p_local_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_loc && core_f < 8'(CORES_PER_CLUSTER) |-> $countones(row & OWN) == 1);
      p_no_stray_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_req |-> row == '0);
   end
endmodule

bind ipi_fast_cluster ipi_fast_cluster_chk #(
   .NUM_CLUSTERS      (NUM_CLUSTERS),
   .CORES_PER_CLUSTER (CORES_PER_CLUSTER)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .fiq         (fiq),
   .set_req     (set_req),
   .retract_req (retract_req),
   .ack_req     (ack_req),
   .due         (due),
   .hit_flat    (hit_flat)
);

// File: tb/ipi_fast_cluster_tb.sv
module ipi_fast_cluster_tb_top;
   localparam int NCL = 2;
   localparam int CPC = 4;
   localparam int N   = NCL * CPC;

   // R1 register select codes
   localparam logic [1:0] S_LOC = 2'd0, S_GLB = 2'd1, S_STA = 2'd2, S_DLY = 2'd3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    wr_en = '0;
   logic [2*N-1:0]  wr_sel = '0;
   logic [32*N-1:0] wr_data = '0;
   logic [2*N-1:0]  rd_sel = '0;
   logic [32*N-1:0] rd_data;
   logic [N-1:0]    fiq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   ipi_fast_cluster #(.NUM_CLUSTERS(NCL), .CORES_PER_CLUSTER(CPC)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .fiq(fiq)
   );

   // R1 word layout: core 7:0, cluster 23:16, kind 29:28
   function automatic logic [31:0] mk(logic [1:0] kind, logic [7:0] clus, logic [7:0] core);
      return {2'b00, kind, 4'h0, clus, 8'h00, core};
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_fiq(string req, logic [N-1:0] exp);
      check(fiq === exp, req, 32'(fiq), 32'(exp));
   endtask

   task automatic put(int c, logic [1:0] sel, logic [31:0] d);
      wr_en[c] = 1'b1;
      wr_sel[2*c +: 2] = sel;
      wr_data[32*c +: 32] = d;
   endtask

   task automatic fire();
      @(posedge clk);
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic rd(int c, logic [1:0] sel, output logic [31:0] v);
      rd_sel[2*c +: 2] = sel;
      #1;
      v = rd_data[32*c +: 32];
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk_fiq("R12 fiq after reset", '0);
      for (int c = 0; c < N; c++) begin
         rd(c, S_STA, v);
         check(v == 0, "R12 status after reset", v, 0);
      end
      rd(0, S_DLY, v);
      check(v == 0, "R8 delay reset value", v, 0);
   endtask

   task automatic t_local();
      logic [31:0] v;
      put(1, S_LOC, mk(2'd0, 8'd1, 8'd2)); fire();
      chk_fiq("R2 R4 local immediate to own cluster", 8'h04);
      put(5, S_LOC, mk(2'd0, 8'd0, 8'd0)); fire();
      chk_fiq("R2 local from cluster 1", 8'h14);
      rd(2, S_STA, v);
      check(v == 32'd1, "R6 status shows pending", v, 1);
      put(2, S_STA, 32'h0); fire();
      chk_fiq("R6 write 0 keeps pending", 8'h14);
      put(2, S_STA, 32'h1); put(4, S_STA, 32'h1); fire();
      chk_fiq("R6 write 1 clears", 8'h00);
   endtask

   task automatic t_global();
      put(0, S_GLB, mk(2'd0, 8'd1, 8'd3)); fire();
      chk_fiq("R3 global to other cluster", 8'h80);
      put(6, S_GLB, mk(2'd3, 8'd0, 8'd1)); fire();
      chk_fiq("R5 no-wake acts as immediate", 8'h82);
      put(7, S_STA, 32'h1); put(1, S_STA, 32'h1); fire();
      chk_fiq("R6 clear two cores", 8'h00);
   endtask

   task automatic t_deferred();
      logic [31:0] v;
      put(3, S_DLY, 32'd5); fire();
      rd(3, S_DLY, v);
      check(v == 32'd5, "R8 delay readback", v, 5);
      put(0, S_GLB, mk(2'd2, 8'd0, 8'd3)); fire();
      repeat (5) @(negedge clk);
      chk_fiq("R7 deferred still waiting", 8'h00);
      @(negedge clk);
      chk_fiq("R7 deferred delivered after V+1", 8'h08);
      put(0, S_GLB, mk(2'd2, 8'd1, 8'd2)); fire();
      chk_fiq("R7 zero delay not immediate", 8'h08);
      @(negedge clk);
      chk_fiq("R7 zero delay after one edge", 8'h48);
      put(3, S_STA, 32'h1); put(6, S_STA, 32'h1); fire();
      chk_fiq("R6 clear deferred results", 8'h00);
   endtask

   task automatic t_retract();
      put(1, S_LOC, mk(2'd2, 8'd0, 8'd3)); fire();
      repeat (2) @(negedge clk);
      put(2, S_GLB, mk(2'd1, 8'd0, 8'd3)); fire();
      repeat (8) @(negedge clk);
      chk_fiq("R9 retract cancels countdown", 8'h00);
      put(4, S_LOC, mk(2'd0, 8'd0, 8'd1)); fire();
      chk_fiq("R4 immediate before retract", 8'h20);
      put(7, S_LOC, mk(2'd1, 8'd0, 8'd1)); fire();
      chk_fiq("R9 retract clears pending", 8'h00);
      put(0, S_LOC, mk(2'd0, 8'd0, 8'd2)); put(1, S_LOC, mk(2'd1, 8'd0, 8'd2)); fire();
      chk_fiq("R9 same-cycle immediate wins", 8'h04);
      put(2, S_STA, 32'h1); fire();
      chk_fiq("R6 clear", 8'h00);
   endtask

   task automatic t_range();
      put(0, S_GLB, mk(2'd0, 8'd0, 8'd4)); fire();
      chk_fiq("R10 core out of range", 8'h00);
      put(0, S_GLB, mk(2'd0, 8'd2, 8'd0)); fire();
      chk_fiq("R10 cluster out of range", 8'h00);
      put(4, S_LOC, mk(2'd0, 8'd7, 8'd1)); fire();
      chk_fiq("R2 local ignores cluster field", 8'h20);
      put(4, S_LOC, mk(2'd0, 8'd0, 8'd9)); fire();
      chk_fiq("R10 local core out of range", 8'h20);
      put(5, S_STA, 32'h1); fire();
      chk_fiq("R6 clear", 8'h00);
   endtask

   task automatic t_concurrent();
      put(0, S_GLB, mk(2'd0, 8'd1, 8'd2));
      put(3, S_GLB, mk(2'd3, 8'd1, 8'd2));
      put(5, S_LOC, mk(2'd0, 8'd0, 8'd3));
      fire();
      chk_fiq("R11 several senders same cycle", 8'hC0);
      put(6, S_STA, 32'h1); put(1, S_GLB, mk(2'd0, 8'd1, 8'd2)); fire();
      chk_fiq("R11 set wins over clear", 8'hC0);
      put(6, S_STA, 32'h1); put(7, S_STA, 32'h1); fire();
      chk_fiq("R6 final clear", 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_local();
      t_global();
      t_deferred();
      t_retract();
      t_range();
      t_concurrent();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule